// File: doc/BRIEF.md
# Key-Sequence Register Lock Controller

This block keeps a control register and its option section shut behind two lock bits. Software opens each one by writing a fixed pair of 32-bit key words, one after the other, to that lock's key register. The main lock guards every field of the control register. The option lock guards only the option-related fields, and those include the option-load launch bit. The option lock can be opened only after the main lock is open.

Software can close either lock again at any time by writing its set bit in the control register. Closing the main lock also closes the option lock. Any key write that breaks a sequence marks that key register as failed. After a failure its lock cannot be opened again until the next reset.

The block watches the decoded bus writes. It outputs both lock states and two same-cycle write qualifiers. The register file uses these qualifiers to accept or drop a control-register write.

Top module: `keylock_ctrl`

## Requirements
- R1: Writing 0x45670123 and then 0xCDEF89AB to the main key register (target code 0) clears lock_o from the cycle after the second write.
- R2: Writing 0x08192A3B and then 0x4C5D6E7F to the option key register (target code 1) while lock_o is low clears optlock_o from the cycle after the second write.
- R3: A control-register write (target code 2) never clears lock_o or optlock_o. Only a completed key sequence clears them.
- R4: A key write that breaks the sequence marks that key register as failed for good, until reset. Such a write is a wrong first word, a wrong second word, a write while that lock is already clear, or any write after a failure. A correct sequence written later then leaves the lock set.
- R5: An option key write made while lock_o is high counts as a failure of the option sequence. optlock_o stays high.
- R6: ctrl_we_o is high only during a control-register write made while lock_o is low.
- R7: opt_we_o is high only during a control-register write made while both lock_o and optlock_o are low.
- R8: An accepted control write with bit 31 set makes both lock_o and optlock_o high on the next cycle. An accepted write with bit 30 set, made while opt_we_o is high, makes optlock_o high.
- R9: Whenever lock_o is high, optlock_o is high too.
- R10: After reset, lock_o and optlock_o are high, both qualifiers are low, and neither key register is marked failed.
- R11: A bus write to any other target between the two key words restarts that key register's sequence. The second key word then counts as a wrong first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_valid_i | input | 1 | A bus write is present this cycle |
| wr_target_i | input | 2 | Decoded target: 0 main key, 1 option key, 2 control, 3 any other register |
| wr_data_i | input | 32 | Write data |
| lock_o | output | 1 | Main lock state (1 = locked) |
| optlock_o | output | 1 | Option lock state (1 = locked) |
| ctrl_we_o | output | 1 | The current control write may update the control fields |
| opt_we_o | output | 1 | The current control write may update the option fields |

## Verification
The bench builds the block with its default parameters: 32-bit data, the two key pairs given above, set bits at positions 31 and 30, and a two-stage reset synchronizer. It counts the synchronizer delay after each reset. These values let the bench reach every failure path. It writes swapped keys, a wrong second word, a key while a lock is already open, option keys while the main lock is closed, and a control write placed between the two key words. After each failure it writes a fresh correct sequence and checks that the lock stays set. It also reopens and relocks both locks more than once, and it samples the qualifiers during every control write.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [1:0] {
    TGT_MAIN_KEY = 2'd0,
    TGT_OPT_KEY  = 2'd1,
    TGT_CTRL     = 2'd2,
    TGT_OTHER    = 2'd3
  } wr_target_e;
endpackage

// File: rtl/keylock_rst_sync.sv
module keylock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;
  logic [N-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[N-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[N-1];
endmodule

// File: rtl/keylock_seq.sv
module keylock_seq #(
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] KEY_FIRST  = '0,
  parameter logic [DATA_W-1:0] KEY_SECOND = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr_i,
  input  logic              other_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              accept_i,
  output logic              unlock_o,
  output logic              failed_o
);
  logic armed_q, armed_d;
  logic failed_q, failed_d;
  logic upd_en;

  assign upd_en = key_wr_i | other_wr_i;

  always_comb begin
    armed_d  = armed_q;
    failed_d = failed_q;
    unlock_o = 1'b0;
    if (key_wr_i) begin
      if (failed_q || !accept_i) begin
        failed_d = 1'b1;
        armed_d  = 1'b0;
      end else if (!armed_q) begin
        if (data_i == KEY_FIRST) armed_d  = 1'b1;
        else                     failed_d = 1'b1;
      end else begin
        armed_d = 1'b0;
        if (data_i == KEY_SECOND) unlock_o = 1'b1;
        else                      failed_d = 1'b1;
      end
    end else if (other_wr_i) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      failed_q <= 1'b0;
    end else if (upd_en) begin
      armed_q  <= armed_d;
      failed_q <= failed_d;
    end
  end

  assign failed_o = failed_q;

  // R4: a failure mark never goes away before reset
  a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    failed_q |=> failed_q);
endmodule

// File: rtl/keylock_state.sv
module keylock_state #(
  parameter int DATA_W      = 32,
  parameter int LOCK_BIT    = 31,
  parameter int OPTLOCK_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              main_unlock_i,
  input  logic              opt_unlock_i,
  output logic              lock_o,
  output logic              optlock_o,
  output logic              ctrl_we_o,
  output logic              opt_we_o
);
  logic lock_q, lock_d;
  logic opt_q, opt_d;
  logic set_lock, set_opt;
  logic upd_en;

  assign ctrl_we_o = ctrl_wr_i & ~lock_q;
  assign opt_we_o  = ctrl_we_o & ~opt_q;
  assign set_lock  = ctrl_we_o & data_i[LOCK_BIT];
  assign set_opt   = set_lock | (opt_we_o & data_i[OPTLOCK_BIT]);
  assign upd_en    = set_lock | set_opt | main_unlock_i | opt_unlock_i;

  always_comb begin
    lock_d = lock_q;
    opt_d  = opt_q;
    if (set_lock)           lock_d = 1'b1;
    else if (main_unlock_i) lock_d = 1'b0;
    if (set_opt)            opt_d  = 1'b1;
    else if (opt_unlock_i)  opt_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      opt_q  <= 1'b1;
    end else if (upd_en) begin
      lock_q <= lock_d;
      opt_q  <= opt_d;
    end
  end

  assign lock_o    = lock_q;
  assign optlock_o = opt_q;

  // R9: the option section is never open while the main lock is closed
  a_r9_lock_implies_optlock: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> opt_q);

  // R3: main lock clears only after a completed main key sequence
  a_r3_lock_fall_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(main_unlock_i));

  // R5: option lock clears only by its key while the main lock was open
  a_r5_optlock_fall_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(opt_q) |-> ($past(opt_unlock_i) && !$past(lock_q)));
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl #(
  parameter int                DATA_W      = 32,
  parameter logic [DATA_W-1:0] MAIN_KEY1   = 32'h4567_0123,
  parameter logic [DATA_W-1:0] MAIN_KEY2   = 32'hCDEF_89AB,
  parameter logic [DATA_W-1:0] OPT_KEY1    = 32'h0819_2A3B,
  parameter logic [DATA_W-1:0] OPT_KEY2    = 32'h4C5D_6E7F,
  parameter int                LOCK_BIT    = 31,
  parameter int                OPTLOCK_BIT = 30,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [1:0]        wr_target_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              lock_o,
  output logic              optlock_o,
  output logic              ctrl_we_o,
  output logic              opt_we_o
);
  import keylock_pkg::*;

  logic rst_n_s;
  logic main_wr, opt_wr, ctrl_wr;
  logic main_unlock, opt_unlock;
  logic main_failed, opt_failed;
  logic main_accept, opt_accept;

  keylock_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  assign main_wr = wr_valid_i && (wr_target_i == TGT_MAIN_KEY);
  assign opt_wr  = wr_valid_i && (wr_target_i == TGT_OPT_KEY);
  assign ctrl_wr = wr_valid_i && (wr_target_i == TGT_CTRL);

  assign main_accept = lock_o;
  assign opt_accept  = optlock_o & ~lock_o;

  keylock_seq #(.DATA_W(DATA_W), .KEY_FIRST(MAIN_KEY1), .KEY_SECOND(MAIN_KEY2)) u_main_seq (
    .clk(clk), .rst_n(rst_n_s), .key_wr_i(main_wr),
    .other_wr_i(wr_valid_i & ~main_wr), .data_i(wr_data_i),
    .accept_i(main_accept), .unlock_o(main_unlock), .failed_o(main_failed)
  );

  keylock_seq #(.DATA_W(DATA_W), .KEY_FIRST(OPT_KEY1), .KEY_SECOND(OPT_KEY2)) u_opt_seq (
    .clk(clk), .rst_n(rst_n_s), .key_wr_i(opt_wr),
    .other_wr_i(wr_valid_i & ~opt_wr), .data_i(wr_data_i),
    .accept_i(opt_accept), .unlock_o(opt_unlock), .failed_o(opt_failed)
  );

  keylock_state #(.DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT), .OPTLOCK_BIT(OPTLOCK_BIT)) u_state (
    .clk(clk), .rst_n(rst_n_s), .ctrl_wr_i(ctrl_wr), .data_i(wr_data_i),
    .main_unlock_i(main_unlock), .opt_unlock_i(opt_unlock),
    .lock_o(lock_o), .optlock_o(optlock_o),
    .ctrl_we_o(ctrl_we_o), .opt_we_o(opt_we_o)
  );

  // R4: a failed main key register never unlocks again
  a_r4_no_main_unlock_after_fail: assert property (@(posedge clk) disable iff (!rst_n_s)
    main_failed |-> !main_unlock);

  // R4: a failed option key register never unlocks again
  a_r4_no_opt_unlock_after_fail: assert property (@(posedge clk) disable iff (!rst_n_s)
    opt_failed |-> !opt_unlock);

  // R6: the control qualifier only accompanies a control-register write
  a_r6_ctrl_we_only_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl_we_o |-> (wr_valid_i && wr_target_i == TGT_CTRL));

  // R8: an accepted write of the lock set bit closes both locks
  a_r8_lock_set_by_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl_we_o && wr_data_i[LOCK_BIT]) |=> (lock_o && optlock_o));
endmodule

// File: tb/keylock_ctrl_tb_top.sv
module keylock_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_valid_i;
  logic [1:0]  wr_target_i;
  logic [31:0] wr_data_i;
  logic        lock_o, optlock_o, ctrl_we_o, opt_we_o;

  int checks = 0;
  int errors = 0;
  logic we_seen, owe_seen;
  bit done = 0;

  localparam logic [31:0] MK1 = 32'h4567_0123;
  localparam logic [31:0] MK2 = 32'hCDEF_89AB;
  localparam logic [31:0] OK1 = 32'h0819_2A3B;
  localparam logic [31:0] OK2 = 32'h4C5D_6E7F;
  localparam logic [1:0] T_MAIN = 2'd0, T_OPT = 2'd1, T_CTRL = 2'd2, T_OTH = 2'd3;

  keylock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_target_i(wr_target_i),
    .wr_data_i(wr_data_i), .lock_o(lock_o), .optlock_o(optlock_o),
    .ctrl_we_o(ctrl_we_o), .opt_we_o(opt_we_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_valid_i = 1'b0; wr_target_i = T_OTH; wr_data_i = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one write: qualifiers captured before the edge, outputs settled after it
  task automatic wr(input logic [1:0] tgt, input logic [31:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_target_i = tgt; wr_data_i = d;
    #1;
    we_seen = ctrl_we_o; owe_seen = opt_we_o;
    @(negedge clk);
    wr_valid_i = 1'b0; wr_target_i = T_OTH; wr_data_i = '0;
    #1;
  endtask

  task automatic open_main();
    wr(T_MAIN, MK1); wr(T_MAIN, MK2);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 lock after reset", lock_o, 1'b1);
    chk("R10 optlock after reset", optlock_o, 1'b1);
    chk("R10 ctrl_we idle", ctrl_we_o, 1'b0);
    chk("R10 opt_we idle", opt_we_o, 1'b0);
    wr(T_CTRL, 32'h0);
    chk("R6 ctrl_we low while locked", we_seen, 1'b0);
    chk("R3 ctrl write keeps lock", lock_o, 1'b1);
  endtask

  task automatic t_good_sequences();
    do_reset();
    wr(T_MAIN, MK1);
    chk("R1 lock held after first key", lock_o, 1'b1);
    wr(T_MAIN, MK2);
    chk("R1 lock cleared", lock_o, 1'b0);
    chk("R9 optlock still set", optlock_o, 1'b1);
    wr(T_CTRL, 32'h0);
    chk("R6 ctrl_we high when open", we_seen, 1'b1);
    chk("R7 opt_we low while optlock", owe_seen, 1'b0);
    chk("R3 lock stays clear", lock_o, 1'b0);
    wr(T_OPT, OK1);
    chk("R2 optlock held after first key", optlock_o, 1'b1);
    wr(T_OPT, OK2);
    chk("R2 optlock cleared", optlock_o, 1'b0);
    wr(T_CTRL, 32'h0);
    chk("R7 opt_we high when both open", owe_seen, 1'b1);
    wr(T_CTRL, 32'h4000_0000);
    chk("R8 bit30 sets optlock", optlock_o, 1'b1);
    chk("R8 bit30 leaves lock", lock_o, 1'b0);
    wr(T_OPT, OK1); wr(T_OPT, OK2);
    chk("R2 option reopens", optlock_o, 1'b0);
    wr(T_CTRL, 32'h8000_0000);
    chk("R8 bit31 sets lock", lock_o, 1'b1);
    chk("R9 bit31 also sets optlock", optlock_o, 1'b1);
    open_main();
    chk("R1 main reopens", lock_o, 1'b0);
  endtask

  task automatic t_opt_while_locked();
    do_reset();
    wr(T_OPT, OK1); wr(T_OPT, OK2);
    chk("R5 optlock stays while main locked", optlock_o, 1'b1);
    open_main();
    wr(T_OPT, OK1); wr(T_OPT, OK2);
    chk("R4 option failed is sticky", optlock_o, 1'b1);
    chk("R1 main unaffected", lock_o, 1'b0);
  endtask

  task automatic t_swapped();
    do_reset();
    wr(T_MAIN, MK2); wr(T_MAIN, MK1);
    chk("R4 swapped keys keep lock", lock_o, 1'b1);
    open_main();
    chk("R4 good sequence after fail", lock_o, 1'b1);
  endtask

  task automatic t_wrong_second();
    do_reset();
    wr(T_MAIN, MK1); wr(T_MAIN, 32'h0);
    chk("R4 wrong second word", lock_o, 1'b1);
    open_main();
    chk("R4 lockout after wrong second", lock_o, 1'b1);
  endtask

  task automatic t_interleave();
    do_reset();
    wr(T_MAIN, MK1);
    wr(T_CTRL, 32'h0);
    chk("R6 interleaved ctrl write gated", we_seen, 1'b0);
    wr(T_MAIN, MK2);
    chk("R11 interleaved write breaks sequence", lock_o, 1'b1);
    open_main();
    chk("R4 lockout after interleave", lock_o, 1'b1);
  endtask

  task automatic t_key_while_open();
    do_reset();
    open_main();
    chk("R1 open before extra key", lock_o, 1'b0);
    wr(T_MAIN, MK1);
    chk("R4 extra key leaves lock clear", lock_o, 1'b0);
    wr(T_CTRL, 32'h8000_0000);
    chk("R8 relock", lock_o, 1'b1);
    open_main();
    chk("R4 lockout after key while open", lock_o, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid_i = 1'b0; wr_target_i = T_OTH; wr_data_i = '0;
    we_seen = 1'b0; owe_seen = 1'b0;
    t_reset_state();
    t_good_sequences();
    t_opt_while_locked();
    t_swapped();
    t_wrong_second();
    t_interleave();
    t_key_while_open();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule